// File: doc/BRIEF.md
# Predicated Vector Leading-Zero Counter

This block executes one vector count-leading-zeros instruction on a 128-bit register value. It decodes a 32-bit instruction word into an element size and two register indices. It counts leading zeros in every lane of the source operand at 8-, 16- or 32-bit width. It then merges the counts into the old destination value under a byte-granular predicate.

Predication always works per byte, whatever the element size. A 16- or 32-bit lane can therefore be partly written: some of its bytes take the count and the rest keep the old destination. The block also checks the instruction word against a fixed opcode pattern and against legal register indices. An illegal word leaves the destination untouched. Results appear one clock after the input strobe.

Top module: `vclz_pred_unit`

## Requirements
- R1: With size field (bits 19:18) = 0, each of the 16 byte lanes holds the leading-zero count of the matching source byte, a value from 0 to 8. Byte 0 is bits 7:0.
- R2: With size field = 1, each of the 8 halfword lanes holds the leading-zero count of its 16-bit source lane. Lane 0 is bits 15:0.
- R3: With size field = 2, each of the 4 word lanes holds the leading-zero count of its 32-bit source lane. Lane 0 is bits 31:0.
- R4: A lane that is all zero yields the lane width (8, 16 or 32).
- R5: Bit b of the predicate mask enables result byte b (bits 8b+7:8b), whatever the element size. An enabled byte takes the count byte. A disabled byte keeps the old destination byte. With mask 0 the output equals the old destination.
- R6: A size field of 3 raises the illegal flag.
- R7: The word is legal only if all of these hold: bits 31:23 are all ones, bits 21:20 = 11, bits 17:16 = 00, bit 12 = 0, bits 11:8 = 0100, bits 7:6 = 11, bit 4 = 0 and bit 0 = 0. Any other word raises the illegal flag.
- R8: The destination index is {bit 22, bits 15:13} and the source index is {bit 5, bits 3:1}. Either index above 7 raises the illegal flag.
- R9: While the illegal flag is raised, the result equals the old destination unchanged.
- R10: out_valid is in_valid delayed by one clock, and result, indices and flag belong to that accepted input. After reset, out_valid, out_illegal, the result and the indices are all zero.
- R11: The decoded destination and source indices are presented with the result, even for an illegal word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; the inputs below are accepted on this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | 128 | Source vector operand |
| in_old | input | 128 | Old destination vector value |
| in_pmask | input | 16 | Byte predicate, bit b enables byte b |
| out_valid | output | 1 | Output strobe, one clock after in_valid |
| out_result | output | 128 | Merged result vector |
| out_dst_idx | output | 4 | Decoded destination register index |
| out_src_idx | output | 4 | Decoded source register index |
| out_illegal | output | 1 | Instruction word is not legal |

## Verification
The assertions take for granted that every input holds a known value on each cycle where in_valid is high. They also take for granted that reset is applied before the first strobe, because their past-value references start at the first strobe after reset. The stimulus drives every input with defined values on the falling edge only and keeps reset low for several cycles at the start. Data and predicate vectors are drawn at random, but the size field and the register indices are chosen so that legal and illegal words, and every element size, all occur.

// File: rtl/vclz_pkg.sv
package vclz_pkg;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_RSVD = 2'd3
  } esz_e;

  typedef struct packed {
    logic       illegal;
    esz_e       esz;
    logic [3:0] dst_idx;
    logic [3:0] src_idx;
  } vclz_dec_t;

  // Opcode pattern: bits that must match, and the value they must hold.
  localparam logic [31:0] OPC_CARE  = 32'hFFB3_1FD1;
  localparam logic [31:0] OPC_VALUE = 32'hFFB0_04C0;

  // Leading zeros of the low n bits of v (n <= 32).
  function automatic logic [5:0] clz_n(input logic [31:0] v, input int n);
    logic [5:0] cnt;
    logic       seen;
    cnt  = '0;
    seen = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && !seen) begin
        if (v[i]) seen = 1'b1;
        else      cnt  = cnt + 6'd1;
      end
    end
    return cnt;
  endfunction

endpackage

// File: rtl/vclz_decode.sv
module vclz_decode
  import vclz_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int NUM_REGS = 8
) (
  input  logic [INSN_W-1:0] insn,
  output vclz_dec_t         dec,
  output logic              opc_ok,
  output logic              size_bad,
  output logic              idx_bad
);
  localparam int IDX_W = 4;

  logic [IDX_W-1:0] dst_w;
  logic [IDX_W-1:0] src_w;

  assign dst_w    = {insn[22], insn[15:13]};
  assign src_w    = {insn[5], insn[3:1]};
  assign opc_ok   = ((insn[31:0] & OPC_CARE) == OPC_VALUE);
  assign size_bad = (insn[19:18] == 2'd3);
  assign idx_bad  = (int'(dst_w) >= NUM_REGS) || (int'(src_w) >= NUM_REGS);

  always_comb begin
    dec.esz     = esz_e'(insn[19:18]);
    dec.dst_idx = dst_w;
    dec.src_idx = src_w;
    dec.illegal = !opc_ok || size_bad || idx_bad;
  end
endmodule

// File: rtl/vclz_lane_array.sv
module vclz_lane_array #(
  parameter int VEC_BYTES = 16,
  parameter int EBYTES    = 1
) (
  input  logic [VEC_BYTES*8-1:0] src,
  output logic [VEC_BYTES*8-1:0] res
);
  localparam int EW    = EBYTES * 8;
  localparam int LANES = VEC_BYTES / EBYTES;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic [31:0] lane_val;
    assign lane_val = 32'(src[e*EW +: EW]);
    assign res[e*EW +: EW] = EW'(vclz_pkg::clz_n(lane_val, EW));
  end
endmodule

// File: rtl/vclz_byte_merge.sv
module vclz_byte_merge #(
  parameter int VEC_BYTES = 16
) (
  input  logic [VEC_BYTES*8-1:0] res,
  input  logic [VEC_BYTES*8-1:0] old,
  input  logic [VEC_BYTES-1:0]   pmask,
  input  logic                   kill,
  output logic [VEC_BYTES-1:0]   byte_en,
  output logic [VEC_BYTES*8-1:0] merged
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    assign byte_en[b]       = pmask[b] & ~kill;
    assign merged[b*8 +: 8] = byte_en[b] ? res[b*8 +: 8] : old[b*8 +: 8];
  end
endmodule

// File: rtl/vclz_pred_unit.sv
module vclz_pred_unit
  import vclz_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int INSN_W    = 32,
  parameter int NUM_REGS  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [INSN_W-1:0]      in_insn,
  input  logic [VEC_BYTES*8-1:0] in_src,
  input  logic [VEC_BYTES*8-1:0] in_old,
  input  logic [VEC_BYTES-1:0]   in_pmask,
  output logic                   out_valid,
  output logic [VEC_BYTES*8-1:0] out_result,
  output logic [3:0]             out_dst_idx,
  output logic [3:0]             out_src_idx,
  output logic                   out_illegal
);
  localparam int VEC_W     = VEC_BYTES * 8;
  localparam int NUM_SIZES = 3;

  vclz_dec_t          dec;
  logic               opc_ok;
  logic               size_bad;
  logic               idx_bad;
  logic               dec_illegal;
  logic [VEC_W-1:0]   lane_res [NUM_SIZES];
  logic [VEC_W-1:0]   sel_res;
  logic [VEC_BYTES-1:0] byte_en;
  logic [VEC_W-1:0]   merged;

  vclz_decode #(.INSN_W(INSN_W), .NUM_REGS(NUM_REGS)) u_dec (
    .insn    (in_insn),
    .dec     (dec),
    .opc_ok  (opc_ok),
    .size_bad(size_bad),
    .idx_bad (idx_bad)
  );

  assign dec_illegal = dec.illegal;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    vclz_lane_array #(.VEC_BYTES(VEC_BYTES), .EBYTES(1 << g)) u_lanes (
      .src(in_src),
      .res(lane_res[g])
    );
  end

  always_comb begin
    case (dec.esz)
      ESZ_HALF: sel_res = lane_res[1];
      ESZ_WORD: sel_res = lane_res[2];
      default:  sel_res = lane_res[0];
    endcase
  end

  vclz_byte_merge #(.VEC_BYTES(VEC_BYTES)) u_merge (
    .res    (sel_res),
    .old    (in_old),
    .pmask  (in_pmask),
    .kill   (dec_illegal),
    .byte_en(byte_en),
    .merged (merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_dst_idx <= '0;
      out_src_idx <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= merged;
        out_dst_idx <= dec.dst_idx;
        out_src_idx <= dec.src_idx;
        out_illegal <= dec_illegal;
      end
    end
  end
endmodule

// File: rtl/vclz_pred_checker.sv
module vclz_pred_checker #(
  parameter int VEC_BYTES = 16,
  parameter int INSN_W    = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic [INSN_W-1:0]      in_insn,
  input logic [VEC_BYTES*8-1:0] in_old,
  input logic [VEC_BYTES-1:0]   in_pmask,
  input logic                   dec_illegal,
  input logic                   out_valid,
  input logic [VEC_BYTES*8-1:0] out_result,
  input logic [3:0]             out_dst_idx,
  input logic [3:0]             out_src_idx,
  input logic                   out_illegal
);
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_size3_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_insn[19:18] == 2'd3) |=> out_illegal);

  p_bad_opcode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_insn[31:23] != 9'h1FF || in_insn[11:8] != 4'h4)) |=> out_illegal);

  p_high_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_insn[22] || in_insn[5])) |=> out_illegal);

  p_illegal_keeps_old_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_illegal) |=> (out_illegal && out_result == $past(in_old)));

  p_no_enable_keeps_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pmask == '0) |=> out_result == $past(in_old));

  p_index_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_dst_idx == {$past(in_insn[22]), $past(in_insn[15:13])} &&
                  out_src_idx == {$past(in_insn[5]), $past(in_insn[3:1])}));
endmodule

bind vclz_pred_unit vclz_pred_checker #(.VEC_BYTES(VEC_BYTES), .INSN_W(INSN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_insn    (in_insn),
  .in_old     (in_old),
  .in_pmask   (in_pmask),
  .dec_illegal(dec_illegal),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_dst_idx(out_dst_idx),
  .out_src_idx(out_src_idx),
  .out_illegal(out_illegal)
);

// File: tb/vclz_pred_unit_bench.sv
`timescale 1ns/1ps
module vclz_pred_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_src = '0;
  logic [127:0] in_old = '0;
  logic [15:0]  in_pmask = '0;
  logic         out_valid;
  logic [127:0] out_result;
  logic [3:0]   out_dst_idx;
  logic [3:0]   out_src_idx;
  logic         out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vclz_pred_unit u_vclz_pred_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .in_src(in_src), .in_old(in_old), .in_pmask(in_pmask),
    .out_valid(out_valid), .out_result(out_result), .out_dst_idx(out_dst_idx),
    .out_src_idx(out_src_idx), .out_illegal(out_illegal)
  );

  // Count zero bits down from the top of an n-bit value.
  function automatic int ref_clz(input logic [31:0] v, input int n);
    int k = n - 1;
    int c = 0;
    while (k >= 0 && v[k] == 1'b0) begin
      c = c + 1;
      k = k - 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] mk(input int sz, input int qd, input int qm);
    logic [31:0] w = 32'hFFB0_04C0;
    w[19:18] = sz[1:0];
    w[22]    = qd[3];
    w[15:13] = qd[2:0];
    w[5]     = qm[3];
    w[3:1]   = qm[2:0];
    return w;
  endfunction

  function automatic bit ref_illegal(input logic [31:0] w);
    bit ok = (w[31:23] == 9'h1FF) && (w[21:20] == 2'b11) && (w[17:16] == 2'b00) &&
             (w[12] == 1'b0) && (w[11:8] == 4'b0100) && (w[7:6] == 2'b11) &&
             (w[4] == 1'b0) && (w[0] == 1'b0);
    return !ok || (w[19:18] == 2'd3) || w[22] || w[5];
  endfunction

  function automatic logic [127:0] ref_result(input logic [31:0] w, input logic [127:0] s,
                                              input logic [127:0] o, input logic [15:0] m);
    logic [127:0] r = o;
    int eb;
    logic [127:0] counts = '0;
    if (ref_illegal(w)) return o;
    eb = 1 << w[19:18];
    for (int e = 0; e < 16 / eb; e++) begin
      logic [31:0] lane = '0;
      for (int k = 0; k < eb * 8; k++) lane[k] = s[e*eb*8 + k];
      counts = counts | (128'(ref_clz(lane, eb * 8)) << (e * eb * 8));
    end
    for (int b = 0; b < 16; b++)
      if (m[b]) r[b*8 +: 8] = counts[b*8 +: 8];
    return r;
  endfunction

  task automatic apply(input string tag, input bit v, input logic [31:0] w,
                       input logic [127:0] s, input logic [127:0] o, input logic [15:0] m);
    logic [127:0] exp_r;
    bit exp_ill;
    @(negedge clk);
    in_valid = v; in_insn = w; in_src = s; in_old = o; in_pmask = m;
    exp_r   = ref_result(w, s, o, m);
    exp_ill = ref_illegal(w);
    @(posedge clk);
    #1;
    checks++;
    if (!v) begin
      if (out_valid !== 1'b0) begin
        failures++;
        $display("FAIL %s out_valid actual=%b expected=0", tag, out_valid);
      end
    end else if (out_valid !== 1'b1 || out_illegal !== exp_ill || out_result !== exp_r ||
                 out_dst_idx !== {w[22], w[15:13]} || out_src_idx !== {w[5], w[3:1]}) begin
      failures++;
      $display("FAIL %s actual v=%b ill=%b d=%0d s=%0d r=%h expected v=1 ill=%b d=%0d s=%0d r=%h",
               tag, out_valid, out_illegal, out_dst_idx, out_src_idx, out_result,
               exp_ill, {w[22], w[15:13]}, {w[5], w[3:1]}, exp_r);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] pat;
    pat = 128'h8040_2010_0804_0201_00FF_7F3F_1F0F_0300;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0 ||
        out_dst_idx !== 4'd0 || out_src_idx !== 4'd0) begin
      failures++;
      $display("FAIL R10 reset actual v=%b r=%h expected v=0 r=0", out_valid, out_result);
    end
    @(negedge clk);
    rst_n = 1'b1;

    apply("R1 byte lanes",       1, mk(0, 1, 2), pat, {4{32'hA5A5_5A5A}}, 16'hFFFF);
    apply("R2 half lanes",       1, mk(1, 3, 4), pat, {4{32'h1234_5678}}, 16'hFFFF);
    apply("R3 word lanes",       1, mk(2, 7, 0), {32'h0000_0001, 32'h8000_0000, 32'h0001_FFFF, 32'h00F0_0000}, '1, 16'hFFFF);
    apply("R4 zero words",       1, mk(2, 0, 0), '0, '1, 16'hFFFF);
    apply("R4 zero bytes",       1, mk(0, 2, 2), '0, '1, 16'hFFFF);
    apply("R4 zero halves",      1, mk(1, 6, 5), '0, '0, 16'hFFFF);
    apply("R5 partial halves",   1, mk(1, 1, 1), pat, {8{16'hBEEF}}, 16'h5555);
    apply("R5 partial words",    1, mk(2, 4, 4), '0, {4{32'hCAFE_F00D}}, 16'hA3C6);
    apply("R5 mask zero",        1, mk(0, 5, 6), pat, {4{32'h0BAD_F00D}}, 16'h0000);
    apply("R6 R9 size three",    1, mk(3, 1, 1), pat, {4{32'h1111_2222}}, 16'hFFFF);
    apply("R7 R9 bit12 set",     1, mk(0, 1, 1) | 32'h0000_1000, pat, {4{32'h3333_4444}}, 16'hFFFF);
    apply("R7 bit0 set",         1, mk(1, 2, 2) | 32'h0000_0001, pat, '0, 16'hFFFF);
    apply("R7 bit23 clear",      1, mk(2, 2, 2) & ~32'h0080_0000, pat, '0, 16'hFFFF);
    apply("R7 bits11_8 wrong",   1, mk(0, 0, 0) ^ 32'h0000_0200, pat, '0, 16'hFFFF);
    apply("R8 R11 dst high",     1, mk(0, 9, 3), pat, {4{32'h5555_6666}}, 16'hFFFF);
    apply("R8 R11 src high",     1, mk(1, 2, 12), pat, {4{32'h7777_8888}}, 16'hFFFF);
    apply("R11 indices legal",   1, mk(2, 5, 3), pat, '0, 16'h0F0F);
    apply("R10 idle",            0, mk(0, 1, 1), pat, '0, 16'hFFFF);
    apply("R10 back to valid",   1, mk(0, 7, 7), ~pat, pat, 16'hFFFF);

    for (int i = 0; i < 60; i++) begin
      int sz = (i % 4 == 3) ? 3 : (i % 3);
      int qd = (i % 11 == 5) ? 10 : (i % 8);
      int qm = (i * 3) % 8;
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] o = {$urandom, $urandom, $urandom, $urandom};
      logic [15:0]  m = 16'($urandom);
      s = s >> ($urandom % 64);
      apply("R1 R2 R3 R5 R6 R8 random", (i % 9) != 4, mk(sz, qd, qm), s, o, m);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule